// File: doc/BRIEF.md
# Configurable UART Transmitter

This block turns bytes written by a host into asynchronous serial frames. A byte written into the holding buffer waits there until the shifter is free. On the next baud tick it is framed from the current control settings and shifted out one bit per tick. The control inputs set the data length (seven, eight or nine bits), parity on or off, the parity kind, the value of the ninth bit, and one or two stop bits. A separate length code selects an internal loopback path. In that mode the frames go to a receiver-side output and the external line stays idle.

The host watches a buffer-empty flag and a transmitting flag. It can also use an interrupt request, gated by an enable input, that tells it when to supply the next byte. A byte written while a frame is on the line goes out straight after that frame's last stop bit, with no idle gap.

Top module: `uart_tx_core`

## Requirements
- R1: After reset `buf_empty_o` is 1. It reads 0 in the cycle after a write (`wr_en` high). It returns to 1 at the baud-tick edge that moves the buffered byte into the shifter.
- R2: `len_code` selects the frame layout: 2'b00 gives eight data bits, 2'b01 gives seven, 2'b10 gives nine, and 2'b11 gives nine-bit loopback. In loopback the frame appears on `loop_o` and `tx_o` stays 1. In the other codes `loop_o` stays 1.
- R3: In the nine-bit codes, `bit9_ctl` is sent as the ninth data bit, directly after the eight byte bits. No parity bit is added.
- R4: With seven or eight data bits and `par_en` = 1, a parity bit follows the data. Its kind is {`par_sel_hi`,`bit9_ctl`]: 00 odd (the data bits plus the parity bit hold an odd number of ones), 01 even, 10 always 1, 11 always 0. With `par_en` = 0 no parity bit is sent.
- R5: Each frame is one start bit at 0, then the data bits LSB first, then the optional ninth or parity bit, then one stop bit at 1. With `two_stop` = 1 there are two stop bits.
- R6: With no frame in progress the serial outputs are 1. The line changes only at clock edges where `baud_tick` is high, so each bit lasts exactly one tick interval. The frame is built from the controls present when its byte is taken.
- R7: `busy_o` rises at the tick that starts a frame. It falls at the tick that ends the last stop bit of the last frame. For one isolated frame of N bits it is high for N tick intervals.
- R8: `irq_o` equals `tx_irq_en` AND buffer-empty, registered. It is 0 whenever `tx_irq_en` was 0 on the previous clock edge.
- R9: If the buffer holds a byte when a frame's last stop bit ends, the next frame's start bit follows at that same tick with no idle bit. `busy_o` stays high across the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse per bit interval |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | DATA_W | Byte to send |
| len_code | input | 2 | Frame-length / loopback code |
| par_en | input | 1 | Parity enable (seven/eight-bit codes) |
| par_sel_hi | input | 1 | Upper parity-kind select |
| bit9_ctl | input | 1 | Ninth data bit, or lower parity-kind select |
| two_stop | input | 1 | Two stop bits when 1 |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| tx_o | output | 1 | External serial line |
| loop_o | output | 1 | Serial stream routed to the receiver in loopback |
| buf_empty_o | output | 1 | Holding buffer empty |
| busy_o | output | 1 | Frame on the line |
| irq_o | output | 1 | Transmit interrupt request |

## Verification
A write shows up as `buf_empty_o` low, and `irq_o` low with it, one clock edge later. The buffer-empty flag and the interrupt return together at the first baud-tick edge that finds the shifter free. The bench therefore samples every result on the falling clock edge after the rising edge it expects the change at. Serial bits change only on tick edges, so the bench records the line on the falling edge after each tick edge. It compares that stream bit for bit with a frame built from the requirements, and also checks that idle bits follow and that the unused pin stays high. `busy_o` is counted over falling edges and must equal the frame length times the tick divider.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    LEN_8      = 2'b00,
    LEN_7      = 2'b01,
    LEN_9      = 2'b10,
    LEN_9_LOOP = 2'b11
  } len_code_e;

  typedef enum logic [1:0] {
    PAR_ODD   = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_MARK  = 2'b10,
    PAR_SPACE = 2'b11
  } par_kind_e;
endpackage

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              short_word,
  input  par_kind_e         kind,
  output logic              par_bit
);
  logic [DATA_W-1:0] mask;
  logic              ones_odd;

  always_comb begin
    mask     = short_word ? {1'b0, {(DATA_W-1){1'b1}}} : {DATA_W{1'b1}};
    ones_odd = ^(data & mask);
    unique case (kind)
      PAR_ODD:   par_bit = ~ones_odd;
      PAR_EVEN:  par_bit = ones_odd;
      PAR_MARK:  par_bit = 1'b1;
      default:   par_bit = 1'b0;
    endcase
  end
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data,
  input  logic [1:0]         len_code,
  input  logic               par_en,
  input  logic               par_sel_hi,
  input  logic               bit9_ctl,
  input  logic               two_stop,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   nbits,
  output logic               lpb
);
  logic      nine;
  logic      seven;
  logic      par_bit;
  par_kind_e kind;
  int        ndata;
  int        pos;

  assign nine  = len_code[1];
  assign seven = (len_code_e'(len_code) == LEN_7);
  assign lpb   = (len_code_e'(len_code) == LEN_9_LOOP);
  assign kind  = par_kind_e'({par_sel_hi, bit9_ctl});

  uart_tx_parity #(.DATA_W(DATA_W)) u_par (
    .data       (data),
    .short_word (seven),
    .kind       (kind),
    .par_bit    (par_bit)
  );

  always_comb begin
    ndata    = seven ? DATA_W - 1 : DATA_W;
    frame    = {FRAME_W{1'b1}};
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < ndata) frame[1+i] = data[i];
    end
    pos = 1 + ndata;
    if (nine) begin
      frame[pos] = bit9_ctl;
      pos        = pos + 1;
    end else if (par_en) begin
      frame[pos] = par_bit;
      pos        = pos + 1;
    end
    nbits = CNT_W'(pos + (two_stop ? 2 : 1));
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
  parameter int FRAME_W = 12,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               have_byte,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CNT_W-1:0]   nbits,
  input  logic               lpb_in,
  output logic               take,
  output logic               line,
  output logic               lpb,
  output logic               busy
);
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   left;
  logic               slot_free;

  assign slot_free = !busy || (left == CNT_W'(1));
  assign take      = tick && have_byte && slot_free;
  assign line      = shreg[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= {FRAME_W{1'b1}};
      left  <= '0;
      busy  <= 1'b0;
      lpb   <= 1'b0;
    end else if (tick) begin
      if (slot_free) begin
        if (have_byte) begin
          shreg <= frame;
          left  <= nbits;
          busy  <= 1'b1;
          lpb   <= lpb_in;
        end else begin
          shreg <= {FRAME_W{1'b1}};
          left  <= '0;
          busy  <= 1'b0;
          lpb   <= 1'b0;
        end
      end else begin
        shreg <= {1'b1, shreg[FRAME_W-1:1]};
        left  <= left - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        len_code,
  input  logic              par_en,
  input  logic              par_sel_hi,
  input  logic              bit9_ctl,
  input  logic              two_stop,
  input  logic              tx_irq_en,
  output logic              tx_o,
  output logic              loop_o,
  output logic              buf_empty_o,
  output logic              busy_o,
  output logic              irq_o
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [DATA_W-1:0]  hold;
  logic               full;
  logic               full_nxt;
  logic               take;
  logic               line;
  logic               lpb;
  logic               lpb_sel;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;
  logic               irq_q;

  uart_tx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
    .data       (hold),
    .len_code   (len_code),
    .par_en     (par_en),
    .par_sel_hi (par_sel_hi),
    .bit9_ctl   (bit9_ctl),
    .two_stop   (two_stop),
    .frame      (frame),
    .nbits      (nbits),
    .lpb        (lpb_sel)
  );

  uart_tx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .tick      (baud_tick),
    .have_byte (full),
    .frame     (frame),
    .nbits     (nbits),
    .lpb_in    (lpb_sel),
    .take      (take),
    .line      (line),
    .lpb       (lpb),
    .busy      (busy_o)
  );

  always_comb begin
    full_nxt = full;
    if (wr_en)     full_nxt = 1'b1;
    else if (take) full_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold  <= '0;
      full  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (wr_en) hold <= wr_data;
      full  <= full_nxt;
      irq_q <= tx_irq_en & ~full_nxt;
    end
  end

  assign buf_empty_o = ~full;
  assign irq_o       = irq_q;
  assign tx_o        = line | lpb;
  assign loop_o      = line | ~lpb;
endmodule

// File: rtl/uart_tx_core_chk.sv
module uart_tx_core_chk (
  input logic clk,
  input logic rst,
  input logic baud_tick,
  input logic wr_en,
  input logic tx_irq_en,
  input logic tx_o,
  input logic loop_o,
  input logic buf_empty_o,
  input logic busy_o,
  input logic irq_o
);
  AST_ONE_PIN_ACTIVE: assert property (@(posedge clk) disable iff (rst) tx_o || loop_o); // R2
  AST_IDLE_MARK:      assert property (@(posedge clk) disable iff (rst) !busy_o |-> (tx_o && loop_o)); // R6
  AST_TICK_PACED:     assert property (@(posedge clk) disable iff (rst) !baud_tick |=> ($stable(busy_o) && $stable(tx_o) && $stable(loop_o))); // R6
  AST_WRITE_FILLS:    assert property (@(posedge clk) disable iff (rst) wr_en |=> !buf_empty_o); // R1
  AST_IRQ_GATED:      assert property (@(posedge clk) disable iff (rst) irq_o |-> $past(tx_irq_en)); // R8
  AST_START_LOW:      assert property (@(posedge clk) disable iff (rst) $rose(busy_o) |-> !(tx_o && loop_o)); // R5
endmodule

bind uart_tx_core uart_tx_core_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .baud_tick   (baud_tick),
  .wr_en       (wr_en),
  .tx_irq_en   (tx_irq_en),
  .tx_o        (tx_o),
  .loop_o      (loop_o),
  .buf_empty_o (buf_empty_o),
  .busy_o      (busy_o),
  .irq_o       (irq_o)
);

// File: tb/tb_uart_tx_core.sv
module tb_uart_tx_core;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] len_code = 2'b00;
  logic       par_en = 1'b0, par_sel_hi = 1'b0, bit9_ctl = 1'b0, two_stop = 1'b0;
  logic       tx_irq_en = 1'b0;
  logic       tx_o, loop_o, buf_empty_o, busy_o, irq_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int tcnt   = 0;
  logic tick_at_edge = 1'b0;

  logic rec_on = 1'b0;
  int   rec_n = 0;
  logic rec_tx [0:63];
  logic rec_lp [0:63];
  logic exp_bits [0:63];
  int   exp_n = 0;

  uart_tx_core #(.DATA_W(8)) dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
    .len_code(len_code), .par_en(par_en), .par_sel_hi(par_sel_hi), .bit9_ctl(bit9_ctl),
    .two_stop(two_stop), .tx_irq_en(tx_irq_en), .tx_o(tx_o), .loop_o(loop_o),
    .buf_empty_o(buf_empty_o), .busy_o(busy_o), .irq_o(irq_o)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tcnt      <= (tcnt == DIV - 1) ? 0 : tcnt + 1;
    baud_tick <= (tcnt == DIV - 1);
  end

  always @(posedge clk) tick_at_edge <= baud_tick;

  always @(negedge clk) begin
    if (rec_on && tick_at_edge && rec_n < 64) begin
      rec_tx[rec_n] = tx_o;
      rec_lp[rec_n] = loop_o;
      rec_n = rec_n + 1;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Frame built from R2..R5: start 0, data LSB first, ninth/parity bit, stops.
  task automatic add_frame(input logic [7:0] d);
    int nd;
    int ones;
    nd = (len_code == 2'b01) ? 7 : 8;
    ones = 0;
    exp_bits[exp_n] = 1'b0; exp_n++;
    for (int i = 0; i < nd; i++) begin
      exp_bits[exp_n] = d[i]; exp_n++;
      ones += d[i];
    end
    if (len_code[1]) begin
      exp_bits[exp_n] = bit9_ctl; exp_n++;
    end else if (par_en) begin
      case ({par_sel_hi, bit9_ctl})
        2'b00: exp_bits[exp_n] = (ones % 2 == 0);
        2'b01: exp_bits[exp_n] = (ones % 2 == 1);
        2'b10: exp_bits[exp_n] = 1'b1;
        default: exp_bits[exp_n] = 1'b0;
      endcase
      exp_n++;
    end
    exp_bits[exp_n] = 1'b1; exp_n++;
    if (two_stop) begin exp_bits[exp_n] = 1'b1; exp_n++; end
  endtask

  task automatic record(input int ticks);
    while (rec_n < ticks) @(negedge clk);
    rec_on = 1'b0;
  endtask

  task automatic check_stream(input string req, input logic use_loop);
    int s;
    int bad;
    s = -1;
    bad = 0;
    for (int i = 0; i < rec_n; i++)
      if (s < 0 && (use_loop ? rec_lp[i] : rec_tx[i]) == 1'b0) s = i;
    if (s < 0) begin
      check({req, " start bit"}, 1, 0);
      return;
    end
    for (int i = s; i < rec_n; i++) begin
      logic e;
      e = (i - s < exp_n) ? exp_bits[i - s] : 1'b1;
      if ((use_loop ? rec_lp[i] : rec_tx[i]) !== e && bad == 0) begin
        bad = 1;
        $display("FAIL %s: bit %0d actual=%0d expected=%0d", req, i - s,
                 use_loop ? rec_lp[i] : rec_tx[i], e);
      end
    end
    checks++;
    if (bad != 0) fails++;
    bad = 0;
    for (int i = 0; i < rec_n; i++)
      if ((use_loop ? rec_tx[i] : rec_lp[i]) !== 1'b1) bad = 1;
    check({req, " R2 unused pin stays high"}, bad, 0);
  endtask

  task automatic run_frame(input string req, input logic [7:0] d, input logic [1:0] lc,
                           input logic pe, input logic hi, input logic b9, input logic st2);
    len_code = lc; par_en = pe; par_sel_hi = hi; bit9_ctl = b9; two_stop = st2;
    exp_n = 0;
    add_frame(d);
    rec_n = 0; rec_on = 1'b1;
    wr_byte(d);
    record(30);
    check_stream(req, lc == 2'b11);
    check({req, " R7 busy low after frame"}, busy_o, 0);
  endtask

  task automatic t_reset();
    check("R1 reset empty", buf_empty_o, 1);
    check("R6 reset tx high", tx_o, 1);
    check("R6 reset loop high", loop_o, 1);
    check("R7 reset not busy", busy_o, 0);
    check("R8 reset irq low", irq_o, 0);
  endtask

  task automatic t_flags();
    int n;
    len_code = 2'b00; par_en = 0; two_stop = 0;
    tx_irq_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R8 irq with empty buffer", irq_o, 1);
    wr_byte(8'h3C);
    check("R1 empty drops after write", buf_empty_o, 0);
    check("R8 irq drops with write", irq_o, 0);
    n = 0;
    while (buf_empty_o == 1'b0 && n < 20) begin @(negedge clk); n++; end
    check("R1 empty returns on tick edge", tick_at_edge, 1);
    check("R8 irq returns with empty", irq_o, 1);
    check("R7 busy at frame start", busy_o, 1);
    tx_irq_en = 1'b0;
    @(negedge clk);
    check("R8 irq gated off", irq_o, 0);
    while (busy_o) @(negedge clk);
  endtask

  task automatic t_busy_len();
    int n;
    len_code = 2'b00; par_en = 1; par_sel_hi = 0; bit9_ctl = 0; two_stop = 1;
    wr_byte(8'hA5);
    while (!busy_o) @(negedge clk);
    n = 0;
    while (busy_o && n < 500) begin n++; @(negedge clk); end
    check("R7 busy width 12 bits", n, 12 * DIV);
  endtask

  task automatic t_back_to_back();
    len_code = 2'b00; par_en = 0; two_stop = 0;
    exp_n = 0;
    add_frame(8'h81);
    add_frame(8'h4E);
    rec_n = 0; rec_on = 1'b1;
    wr_byte(8'h81);
    while (!buf_empty_o) @(negedge clk);
    wr_byte(8'h4E);
    check("R9 busy held across frames", busy_o, 1);
    record(40);
    check_stream("R9 back-to-back", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_flags();
    run_frame("R5 8N1 LSB first",       8'hB2, 2'b00, 0, 0, 0, 0);
    run_frame("R5 two stop bits",       8'h0F, 2'b00, 0, 0, 0, 1);
    run_frame("R2 R4 seven odd",        8'hE5, 2'b01, 1, 0, 0, 0);
    run_frame("R4 eight even",          8'h07, 2'b00, 1, 0, 1, 0);
    run_frame("R4 eight odd",           8'h07, 2'b00, 1, 0, 0, 0);
    run_frame("R4 mark parity",         8'h00, 2'b00, 1, 1, 0, 0);
    run_frame("R4 space parity",        8'hFF, 2'b01, 1, 1, 1, 1);
    run_frame("R3 nine bit one",        8'h5A, 2'b10, 1, 0, 1, 0);
    run_frame("R3 nine bit zero",       8'hC3, 2'b10, 0, 0, 0, 1);
    run_frame("R2 loopback nine bit",   8'h96, 2'b11, 0, 0, 1, 0);
    t_busy_len();
    t_back_to_back();
    summary();
  end
endmodule